// File: doc/BRIEF.md
# Timer-Triggered Conversion Sequencer

This block is the control logic for an analog-to-digital converter that runs in timer-trigger mode. Eight timer event lines feed it. They come from two timers, and each timer supplies two conversion triggers and two counter-reversal events. While the block is armed, any one of these events starts a conversion of the selected analog channel. There are ten channels. The converter core is abstract: it is modelled as a counter that runs for a fixed number of cycles, after which the value on the data input is taken as the result.

Each finished conversion stores its value in the result register that belongs to the converted channel. In the same cycle, the block raises a one-cycle end-of-conversion interrupt. After that it goes back to waiting for the next timer event, and it keeps doing so for as long as it stays armed. Two things abort a running conversion and start it again from the beginning: a new timer event, or a write to the control registers. Disarming the block during a conversion discards that conversion.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, `busy`, `conv_start` and `eoc_irq` are 0 and every result register is 0.
- R2: While `arm` is 0, timer events are ignored: `busy` and `conv_start` stay 0.
- R3: While armed and idle, an event on any single bit of `trig_evt` (bits 0 to 7) starts a conversion. `busy` and a one-cycle `conv_start` pulse appear in the cycle after the event.
- R4: `busy` stays 1 for exactly `CONV_CYCLES` cycles. In the cycle where it falls, `eoc_irq` is 1 for one cycle.
- R5: When a conversion completes, `conv_data` is stored in the register of the channel that `chan_sel` held at the last start or restart. Channel i occupies `results[i*DATA_W +: DATA_W]`, and all other registers keep their values.
- R6: A timer event during a conversion restarts it. A new `conv_start` pulse appears, and completion comes `CONV_CYCLES` cycles after the restart.
- R7: A `reg_wr` pulse during a conversion restarts it in the same way as R6. A `reg_wr` pulse while idle has no effect.
- R8: A timer event and a `reg_wr` in the same cycle produce a single restart: one `conv_start` pulse and one completion.
- R9: Dropping `arm` mid-conversion clears `busy` in the next cycle. No interrupt is raised and no result is stored.
- R10: After a completion, the block re-arms without software action, and the next event starts a new conversion.
- R11: If `chan_sel` is 10 or above, the conversion still runs and raises `eoc_irq`, but no result register changes.
- R12: A timer event in the final cycle of a conversion restarts it. The completion, the interrupt and the store are all suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Enables timer-triggered conversion |
| chan_sel | input | CH_W | Channel to convert |
| reg_wr | input | 1 | Strobe for a control-register write |
| trig_evt | input | N_TRIG | Timer trigger and reversal events |
| conv_data | input | DATA_W | Value produced by the converter core |
| conv_start | output | 1 | Start/restart pulse to the core |
| busy | output | 1 | Conversion in progress |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |
| results | output | N_CH*DATA_W | Per-channel result registers |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a restart and a completion: a trigger is driven in exactly the last counting cycle. The bench expects a fresh `conv_start`, `busy` held high, no interrupt and unchanged registers, followed by a full new count. The second pair is a trigger and a register write arriving together. The bench checks that this yields one start pulse and exactly one completion, `CONV_CYCLES` cycles later.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  // A channel code addresses a result register only when it is in range.
  function automatic logic chan_ok(input int unsigned code, input int unsigned n_ch);
    return code < n_ch;
  endfunction

  // Counter preload: the core expires after the preload has counted down to zero.
  function automatic int unsigned cnt_preload(input int unsigned cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

endpackage

// File: rtl/adc_trig_merge.sv
module adc_trig_merge #(
  parameter int unsigned N_TRIG = 8
) (
  input  logic [N_TRIG-1:0] trig,
  output logic              evt_any
);
  logic [N_TRIG:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N_TRIG; g++) begin : g_or
    assign chain[g+1] = chain[g] | trig[g];
  end

  assign evt_any = chain[N_TRIG];
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int unsigned CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(cnt_preload(CONV_CYCLES));

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= RELOAD;
    else if (run && cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire = run && (cnt_q == '0);

  // R6: any reload starts the count from the top
  p_reload_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == RELOAD);

  // R4: the counter never leaves its window
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned N_CH   = 10,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned CH_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CH_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [N_CH*DATA_W-1:0] results
);
  logic [N_CH-1:0] we_vec;

  for (genvar g = 0; g < N_CH; g++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    assign we_vec[g] = wr_en && (wr_idx == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         val_q <= '0;
      else if (we_vec[g]) val_q <= wr_data;
    end
    assign results[g*DATA_W +: DATA_W] = val_q;
  end

  // R5: at most one register is written per cycle
  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));

  // R5: untouched registers hold their value
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(results));
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_CH        = 10,
  parameter int unsigned N_TRIG      = 8,
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned CONV_CYCLES = 12,
  parameter int unsigned CH_W        = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm,
  input  logic [CH_W-1:0]        chan_sel,
  input  logic                   reg_wr,
  input  logic [N_TRIG-1:0]      trig_evt,
  input  logic [DATA_W-1:0]      conv_data,
  output logic                   conv_start,
  output logic                   busy,
  output logic                   eoc_irq,
  output logic [N_CH*DATA_W-1:0] results
);
  seq_state_e        state_q, state_d;
  logic              evt_any_w;
  logic              load_w;
  logic              run_w;
  logic              done_w;
  logic              store_w;
  logic [CH_W-1:0]   chan_q;
  logic              start_q;
  logic              irq_q;

  adc_trig_merge #(.N_TRIG(N_TRIG)) i_merge (
    .trig    (trig_evt),
    .evt_any (evt_any_w)
  );

  // Start from idle on an event; restart while busy on event or register write.
  assign load_w = arm && (evt_any_w || (state_q == SEQ_BUSY && reg_wr));
  assign run_w  = arm && (state_q == SEQ_BUSY) && !load_w;

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_w),
    .run    (run_w),
    .expire (done_w)
  );

  always_comb begin
    state_d = state_q;
    if (!arm)        state_d = SEQ_IDLE;
    else if (load_w) state_d = SEQ_BUSY;
    else if (done_w) state_d = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      chan_q  <= '0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= load_w;
      irq_q   <= done_w;
      if (load_w) chan_q <= chan_sel;
    end
  end

  assign store_w = done_w && chan_ok(int'(chan_q), N_CH);

  adc_result_bank #(.N_CH(N_CH), .DATA_W(DATA_W), .CH_W(CH_W)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_w),
    .wr_idx  (chan_q),
    .wr_data (conv_data),
    .results (results)
  );

  assign conv_start = start_q;
  assign busy       = (state_q == SEQ_BUSY);
  assign eoc_irq    = irq_q;

  // R4: the interrupt lasts one cycle
  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);

  // R4: the interrupt coincides with the fall of busy
  p_irq_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> !busy);

  // R3: a start pulse is always accompanied by busy
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  // R2 / R9: disarmed means idle and silent next cycle
  p_disarm_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (!busy && !eoc_irq && !conv_start));

  // R6: an event while busy restarts
  p_evt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && arm && evt_any_w) |=> (conv_start && busy));

  // R7: a register write while idle starts nothing
  p_idle_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !evt_any_w) |=> !conv_start);

  // R12: a restart suppresses completion in the same cycle
  p_restart_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> !eoc_irq);
endmodule

// File: tb/test_adc_trig_seq.sv
module test_adc_trig_seq;
  localparam int unsigned N_CH   = 10;
  localparam int unsigned N_TRIG = 8;
  localparam int unsigned DATA_W = 10;
  localparam int unsigned NCYC   = 6;
  localparam int unsigned CH_W   = 4;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   arm = 1'b0;
  logic [CH_W-1:0]        chan_sel = '0;
  logic                   reg_wr = 1'b0;
  logic [N_TRIG-1:0]      trig_evt = '0;
  logic [DATA_W-1:0]      conv_data = '0;
  logic                   conv_start, busy, eoc_irq;
  logic [N_CH*DATA_W-1:0] results;
  logic [N_CH*DATA_W-1:0] exp_res = '0;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  adc_trig_seq #(.N_CH(N_CH), .N_TRIG(N_TRIG), .DATA_W(DATA_W),
                 .CONV_CYCLES(NCYC), .CH_W(CH_W)) i_adc_trig_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .chan_sel(chan_sel), .reg_wr(reg_wr),
    .trig_evt(trig_evt), .conv_data(conv_data), .conv_start(conv_start),
    .busy(busy), .eoc_irq(eoc_irq), .results(results)
  );

  // fields: [16:14] trigger bit, [13:10] channel, [9:0] data
  localparam logic [16:0] VEC [8] = '{
    {3'd0, 4'd0, 10'h15A}, {3'd1, 4'd9, 10'h3FF}, {3'd2, 4'd4, 10'h001},
    {3'd3, 4'd7, 10'h2C3}, {3'd4, 4'd1, 10'h0F0}, {3'd5, 4'd0, 10'h222},
    {3'd6, 4'd5, 10'h13B}, {3'd7, 4'd2, 10'h300}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive a one-cycle stimulus; returns at the negedge after the sampling edge
  task automatic fire(input logic [N_TRIG-1:0] t, input logic w);
    trig_evt = t;
    reg_wr = w;
    tick();
    trig_evt = '0;
    reg_wr = 1'b0;
  endtask

  // called one negedge after a start/restart edge; runs to completion
  task automatic follow(input int ch, input logic [DATA_W-1:0] d, input string req);
    check({req, " start pulse"}, 128'(conv_start), 128'(1));
    check({req, " busy set"}, 128'(busy), 128'(1));
    for (int i = 1; i < int'(NCYC); i++) begin
      tick();
      check({req, " busy held R4"}, 128'({busy, eoc_irq, conv_start}), 128'(3'b100));
    end
    tick();
    if (ch < int'(N_CH)) exp_res[ch*DATA_W +: DATA_W] = d;
    check({req, " done R4"}, 128'({busy, eoc_irq}), 128'(2'b01));
    check({req, " results R5"}, 128'(results), 128'(exp_res));
    tick();
    check({req, " irq one cycle R4"}, 128'(eoc_irq), 128'(0));
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick();
    tick();
    check("R1 reset outputs", 128'({busy, conv_start, eoc_irq}), 128'(0));
    check("R1 reset results", 128'(results), 128'(0));
    rst_n = 1'b1;
    tick();

    // R2: disarmed, all events ignored
    fire('1, 1'b1);
    check("R2 ignored busy", 128'({busy, conv_start}), 128'(0));
    tick();
    check("R2 still idle", 128'({busy, conv_start, eoc_irq}), 128'(0));

    arm = 1'b1;
    tick();

    // R7: register write while idle does nothing
    fire('0, 1'b1);
    check("R7 idle write", 128'({busy, conv_start}), 128'(0));

    // R3 / R5 / R10: table walk, one trigger source per entry, back to back
    foreach (VEC[k]) begin
      chan_sel = VEC[k][13:10];
      conv_data = VEC[k][9:0];
      fire(N_TRIG'(1) << VEC[k][16:14], 1'b0);
      follow(int'(VEC[k][13:10]), VEC[k][9:0], "R3 R10 vector");
    end

    // R6: trigger mid-conversion restarts; channel re-latched
    chan_sel = 4'd3; conv_data = 10'h0AA;
    fire(8'h01, 1'b0);
    tick(); tick();
    chan_sel = 4'd6;
    fire(8'h20, 1'b0);
    follow(6, 10'h0AA, "R6 restart");

    // R7: register write mid-conversion restarts
    chan_sel = 4'd8; conv_data = 10'h155;
    fire(8'h04, 1'b0);
    tick(); tick(); tick();
    fire('0, 1'b1);
    follow(8, 10'h155, "R7 write restart");

    // R8: trigger and write together give a single restart
    chan_sel = 4'd1; conv_data = 10'h2E7;
    fire(8'h02, 1'b0);
    tick();
    fire(8'h80, 1'b1);
    follow(1, 10'h2E7, "R8 coincide");

    // R9: disarm mid-conversion aborts silently
    chan_sel = 4'd4; conv_data = 10'h111;
    fire(8'h08, 1'b0);
    tick();
    arm = 1'b0;
    tick();
    check("R9 busy cleared", 128'(busy), 128'(0));
    for (int i = 0; i < int'(NCYC) + 2; i++) begin
      tick();
      check("R9 no irq", 128'(eoc_irq), 128'(0));
    end
    check("R9 no store", 128'(results), 128'(exp_res));
    arm = 1'b1;
    tick();

    // R11: out-of-range channel runs but stores nothing
    chan_sel = 4'd12; conv_data = 10'h3A5;
    fire(8'h10, 1'b0);
    follow(12, 10'h3A5, "R11 bad channel");

    // R12: trigger in the final counting cycle restarts, no completion
    chan_sel = 4'd7; conv_data = 10'h0C4;
    fire(8'h40, 1'b0);
    for (int i = 1; i < int'(NCYC); i++) tick();
    fire(8'h01, 1'b0);
    check("R12 no irq", 128'({busy, eoc_irq}), 128'(2'b10));
    check("R12 no store", 128'(results), 128'(exp_res));
    follow(7, 10'h0C4, "R12 late restart");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule